// File: doc/BRIEF.md
# I2C SCL Clock Synchronizer

This block decides when a device pulls the shared, open-drain I2C clock wire low. Two sources can ask for a low: a clock-release control bit, held inside the block and written through a one-bit write port (cleared means "stretch the clock"), and a pull-low request from the surrounding master logic. Neither is acted on while the wire is high. The block only starts driving once its synchronized copy of SCL has already been seen low, so it joins an existing low period and never cuts another master's high period short.

When both sources withdraw, the output enable drops at once. The block then reports the clock as high only after the synchronized wire reads high, which is the moment every device on the bus has let go. This clock-high indicator is where any downstream high-time counter should start. The raw SCL level passes through a two-flop synchronizer, and the output enable is a register on the system clock.

Top module: `scl_clk_sync`

## Requirements
- R1: During reset, `scl_oe` is 0, `scl_high` is 0 and `rel_rdata` (the clock-release bit) is 1.
- R2: A cycle with `rel_wr` high loads `rel_wdata` into the clock-release bit, and `rel_rdata` shows it from the next cycle. Without `rel_wr`, the bit holds its value.
- R3: While the synchronized SCL reads high, `scl_oe` is never asserted, whatever the clock-release bit and `pull_req` are. This protects the high time of every master.
- R4: When the clock-release bit is 0 or `pull_req` is 1, and the synchronized SCL reads low, `scl_oe` goes to 1 on the next clock. With two synchronizer stages, this is the third clock edge after the wire falls.
- R5: `scl_oe` stays at 1 for as long as the clock-release bit is 0 or `pull_req` is 1.
- R6: Once the clock-release bit is 1 and `pull_req` is 0, `scl_oe` drops on the next clock.
- R7: After a release, `scl_high` rises only after the synchronized SCL reads high. It stays 0 for as long as any other device keeps the wire low.
- R8: A new low request that arrives while the block waits for other devices to release the wire is acted on at the next clock, because the wire is already low.
- R9: `scl_high` drops one clock after the synchronized SCL reads low.
- R10: SCL is sampled through a two-stage synchronizer that resets to low. After reset, `scl_high` first rises on the third clock edge once the wire reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rel_wr | input | 1 | Write strobe for the clock-release bit |
| rel_wdata | input | 1 | Value written to the clock-release bit (0 = stretch) |
| pull_req | input | 1 | Request from the master logic to hold SCL low |
| scl_in | input | 1 | Raw level of the SCL wire |
| scl_oe | output | 1 | Pull SCL low when 1, release it when 0 |
| scl_high | output | 1 | Synchronized clock-high indicator |
| rel_rdata | output | 1 | Current value of the clock-release bit |

## Verification
The bench models the wire as a wired-AND of the block's enable and a second device's pull. It raises low requests, from `pull_req` and from a cleared release bit, while the wire is high. No drive must appear until the other device pulls low, which separates a correct synchronizer join from one that drives straight away. Three release orders are tried: the block releases first while the other device still holds the wire; the other device lets go first; and a new request arrives in the middle of the release wait. These show whether `scl_high` waits for every device and whether a re-drive is taken only on a wire that is already low. Every expected edge is placed on an exact cycle, so one synchronizer stage too many or too few shows up as a mismatch.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

  // Line view held by the controller.
  typedef enum logic [1:0] {
    ST_HIGH     = 2'd0,  // wire seen high, not driving
    ST_EXT_LOW  = 2'd1,  // wire low from someone else, no request
    ST_DRIVE    = 2'd2,  // holding the wire low
    ST_REL_WAIT = 2'd3   // released, wire not yet seen high
  } scl_state_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/scl_bit_sync.sv
module scl_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/scl_rel_reg.sv
module scl_rel_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_data,
  output logic rel_q
);

  logic rel_d;

  always_comb begin
    rel_d = rel_q;
    if (wr_en) rel_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b1;
    else        rel_q <= rel_d;
  end

  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rel_q == $past(wr_data)));

  assert_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rel_q));

endmodule

// File: rtl/scl_sync_fsm.sv
module scl_sync_fsm
  import scl_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rel_bit,
  input  logic pull_req,
  input  logic scl_s,
  output logic scl_oe,
  output logic scl_high
);

  scl_state_e state_q, state_d;
  logic       want_low;

  assign want_low = pull_req | ~rel_bit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HIGH: begin
        if (!scl_s) state_d = want_low ? ST_DRIVE : ST_EXT_LOW;
      end
      ST_EXT_LOW: begin
        if (scl_s)         state_d = ST_HIGH;
        else if (want_low) state_d = ST_DRIVE;
      end
      ST_DRIVE: begin
        if (!want_low) state_d = ST_REL_WAIT;
      end
      ST_REL_WAIT: begin
        if (scl_s)         state_d = ST_HIGH;
        else if (want_low) state_d = ST_DRIVE;
      end
      default: state_d = ST_REL_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_REL_WAIT;
    else        state_q <= state_d;
  end

  assign scl_oe   = (state_q == ST_DRIVE);
  assign scl_high = (state_q == ST_HIGH);

  assert_drive_joins_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !$past(scl_s));

  assert_low_request_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !scl_s && want_low) |=> scl_oe);

  assert_no_drive_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && scl_s) |=> !scl_oe);

  assert_drive_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && want_low) |=> scl_oe);

  assert_drive_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !want_low) |=> !scl_oe);

  assert_high_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_high) |-> ($past(scl_s) && !$past(scl_oe)));

  assert_high_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_high && !scl_s) |=> !scl_high);

endmodule

// File: rtl/scl_clk_sync.sv
module scl_clk_sync #(
  parameter int unsigned SYNC_STAGES = scl_sync_pkg::SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rel_wr,
  input  logic rel_wdata,
  input  logic pull_req,
  input  logic scl_in,
  output logic scl_oe,
  output logic scl_high,
  output logic rel_rdata
);

  logic scl_s;
  logic rel_bit;

  scl_bit_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (scl_in),
    .q     (scl_s)
  );

  scl_rel_reg u_rel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rel_wr),
    .wr_data (rel_wdata),
    .rel_q   (rel_bit)
  );

  scl_sync_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rel_bit  (rel_bit),
    .pull_req (pull_req),
    .scl_s    (scl_s),
    .scl_oe   (scl_oe),
    .scl_high (scl_high)
  );

  assign rel_rdata = rel_bit;

endmodule

// File: tb/scl_clk_sync_bench.sv
`timescale 1ns/1ps
module scl_clk_sync_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic rel_wr, rel_wdata, pull_req, ext_pull;
  logic scl_in, scl_oe, scl_high, rel_rdata;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;

  typedef struct {
    int    when;
    bit    oe;
    bit    hi;
    bit    rel;
    string tag;
  } exp_t;
  exp_t exq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // wired-AND bus: low if this block or the other device pulls
  assign scl_in = ~(scl_oe | ext_pull);

  scl_clk_sync u_scl_clk_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rel_wr    (rel_wr),
    .rel_wdata (rel_wdata),
    .pull_req  (pull_req),
    .scl_in    (scl_in),
    .scl_oe    (scl_oe),
    .scl_high  (scl_high),
    .rel_rdata (rel_rdata)
  );

  task automatic expect_at(int dly, bit oe, bit hi, bit rel, string tag);
    exp_t e;
    e.when = cyc + dly;
    e.oe   = oe;
    e.hi   = hi;
    e.rel  = rel;
    e.tag  = tag;
    exq.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (exq.size() != 0) begin
      n_fail++;
      $display("FAIL %s: %0d expected items never compared (actual) vs 0 (expected)",
               exq[0].tag, exq.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: compare due items shortly after each rising edge
  always begin
    @(posedge clk);
    #1;
    for (int i = exq.size() - 1; i >= 0; i--) begin
      if (exq[i].when == cyc) begin
        n_chk++;
        if (scl_oe !== exq[i].oe || scl_high !== exq[i].hi || rel_rdata !== exq[i].rel) begin
          n_fail++;
          $display("FAIL %s @cyc %0d: oe/high/rel = %b%b%b expected %b%b%b",
                   exq[i].tag, cyc, scl_oe, scl_high, rel_rdata,
                   exq[i].oe, exq[i].hi, exq[i].rel);
        end
        exq.delete(i);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run still active at cycle %0d (actual) vs done (expected)", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rel_wr = 1'b0; rel_wdata = 1'b1; pull_req = 1'b0; ext_pull = 1'b0;
    tick(1);
    expect_at(1, 0, 0, 1, "R1 reset state");
    expect_at(2, 0, 0, 1, "R1 reset state");
    tick(3);
    rst_n = 1'b1;
    expect_at(2, 0, 0, 1, "R10 sync latency before high");
    expect_at(3, 0, 1, 1, "R10 high after sync");
    tick(5);

    // R3: request with line high, nothing happens
    pull_req = 1'b1;
    for (int k = 1; k <= 6; k++) expect_at(k, 0, 1, 1, "R3 no drive on high");
    tick(7);
    // other device pulls low: join
    ext_pull = 1'b1;
    expect_at(2, 0, 1, 1, "R9 high before sync");
    expect_at(3, 1, 0, 1, "R4 drive after low seen");
    tick(4);
    ext_pull = 1'b0;
    for (int k = 1; k <= 4; k++) expect_at(k, 1, 0, 1, "R5 hold while requested");
    tick(5);
    pull_req = 1'b0;
    expect_at(1, 0, 0, 1, "R6 drop on withdraw");
    expect_at(3, 0, 0, 1, "R7 wait for synced high");
    expect_at(4, 0, 1, 1, "R7 high after release");
    tick(6);

    // R2: clear release bit while high
    rel_wr = 1'b1; rel_wdata = 1'b0;
    expect_at(1, 0, 1, 0, "R2 bit written");
    for (int k = 2; k <= 4; k++) expect_at(k, 0, 1, 0, "R3 cleared bit no drive on high");
    tick(1);
    rel_wr = 1'b0; rel_wdata = 1'b1;
    expect_at(2, 0, 1, 0, "R2 bit holds");
    tick(4);
    ext_pull = 1'b1;
    expect_at(3, 1, 0, 0, "R4 stretch joins low");
    tick(4);
    ext_pull = 1'b0;
    for (int k = 1; k <= 3; k++) expect_at(k, 1, 0, 0, "R5 stretch held");
    tick(4);
    rel_wr = 1'b1; rel_wdata = 1'b1;
    expect_at(1, 1, 0, 1, "R6 write seen next cycle");
    expect_at(2, 0, 0, 1, "R6 release after bit set");
    expect_at(4, 0, 0, 1, "R7 wait for synced high");
    expect_at(5, 0, 1, 1, "R7 high after release");
    tick(1);
    rel_wr = 1'b0;
    tick(6);

    // R4 from an external low with no request
    ext_pull = 1'b1;
    expect_at(3, 0, 0, 1, "R9 external low, no drive");
    tick(4);
    pull_req = 1'b1;
    expect_at(1, 1, 0, 1, "R4 request on low line");
    tick(2);
    // R7: block releases first, other device still holds
    pull_req = 1'b0;
    for (int k = 1; k <= 8; k++) expect_at(k, 0, 0, 1, "R7 other device holds");
    tick(9);
    // R8: new request during release wait
    pull_req = 1'b1;
    expect_at(1, 1, 0, 1, "R8 redrive on held line");
    tick(2);
    pull_req = 1'b0;
    expect_at(1, 0, 0, 1, "R6 drop again");
    tick(2);
    ext_pull = 1'b0;
    expect_at(2, 0, 0, 1, "R7 still syncing");
    expect_at(3, 0, 1, 1, "R7 high once all released");
    tick(6);

    finish_run();
  end

endmodule